// File: doc/BRIEF.md
# Flash Cell Array with Injectable Disturb Faults

This block is a small synthesizable model of a bit-oriented flash cell array, meant to sit in front of a memory self-test engine as its device under test. Cells start erased at 1. An erase command sets the whole array back to 1. A program command can only clear one addressed cell to 0. A read command returns one bit. Each command is handed over with a valid/ready handshake. While the array is working on an accepted command, ready stays low. Read results come back on a one-cycle response strobe, and there is no back-pressure on that strobe.

A fault-configuration port chooses at most one fault and gives the aggressor and victim coordinates. The faults are:
- word-line program disturb and word-line erase disturb;
- bit-line program disturb and bit-line erase disturb;
- read disturb;
- over-erase.

A self-test engine can be run against each fault in turn, and its detection logic can be judged against a known answer.

Command back-pressure follows these rules:
- A command moves only on a rising edge where both `cmd_valid` and `cmd_ready` are high.
- While `cmd_ready` is low, the command inputs are not looked at.
- A source may hold `cmd_valid` across busy cycles. Only the first ready edge consumes the command.

Top module: `flash_disturb_array`

## Requirements
- R1: After reset every cell holds 1, `cmd_ready` is 1 and `rd_valid` is 0.
- R2: `cmd_op` encodes 0 no-op, 1 erase, 2 program and 3 read. A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both high. After that edge, `cmd_ready` stays low for ERASE_CYC cycles after an erase, PROG_CYC cycles after a program and 1 cycle after a read. Commands presented while `cmd_ready` is low change nothing.
- R3: An accepted erase sets every cell to 1.
- R4: An accepted program clears only the addressed cell to 0. No command writes a 1 into a single addressed cell.
- R5: An accepted read raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` holds the addressed cell's value as it was at the accept edge.
- R6: `flt_type` encodes 0 none, 1 word-line program disturb, 2 word-line erase disturb, 3 bit-line program disturb, 4 bit-line erase disturb, 5 read disturb and 6 over-erase. Value 7 behaves as none. The type and coordinates are captured on every edge where `cmd_ready` is high, and they govern commands accepted on later edges. Changes made while `cmd_ready` is low are not captured.
- R7: Under type 1, when the aggressor holds 1 and is programmed, and it shares the victim's row, the victim becomes 0.
- R8: Under type 2, when the aggressor holds 1 and is programmed, and it shares the victim's row, the victim becomes 1.
- R9: Types 3 and 4 act like types 1 and 2, except that the aggressor must share the victim's column instead of its row.
- R10: A disturb never fires when the aggressor already holds 0, when it sits on the victim itself, or when it is not on the required line. Cells other than the victim are never disturbed.
- R11: Under type 5, a read of the victim while it holds 0 returns 0, and the victim holds 1 afterwards. Reads of other cells are unaffected.
- R12: Under type 6, programming the victim leaves it at 1. Reads of any other row in the victim's column return 1. Cells in other columns read normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Array idle, command can be taken |
| cmd_op | input | 2 | Command code |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | COL_W | Column address |
| flt_type | input | 3 | Fault selection |
| flt_agg_row | input | ROW_W | Aggressor row |
| flt_agg_col | input | COL_W | Aggressor column |
| flt_vic_row | input | ROW_W | Victim row |
| flt_vic_col | input | COL_W | Victim column |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 1 | Read result bit |

## Verification
Two of the block's functions can fall on one edge.

The first pair is a read and a read disturb. A read of a read-disturb victim holding 0 must return the old 0 on the same edge that flips the cell to 1. The bench programs the victim, reads it expecting 0, and then reads it again expecting 1.

The second pair is a program and a cross-cell disturb. Programming an aggressor clears that cell and, on the same edge, moves the victim. The bench checks both cells afterwards through ordinary reads, and also checks a neighbour that must stay untouched.

// File: rtl/flash_fault_pkg.sv
package flash_fault_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_READ  = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    FLT_NONE       = 3'd0,
    FLT_WL_PROG    = 3'd1,
    FLT_WL_ERASE   = 3'd2,
    FLT_BL_PROG    = 3'd3,
    FLT_BL_ERASE   = 3'd4,
    FLT_READ_DIST  = 3'd5,
    FLT_OVER_ERASE = 3'd6
  } flt_kind_e;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_fault_pkg::*;
#(
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  flash_op_e op,
  output logic      busy
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      case (op)
        OP_ERASE: cnt_q <= CNT_W'(ERASE_CYC);
        OP_PROG:  cnt_q <= CNT_W'(PROG_CYC);
        OP_READ:  cnt_q <= CNT_W'(1);
        OP_NOP:   cnt_q <= '0;
      endcase
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/flash_fault_cfg.sv
module flash_fault_cfg
  import flash_fault_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [2:0]       type_in,
  input  logic [ROW_W-1:0] agg_row_in,
  input  logic [COL_W-1:0] agg_col_in,
  input  logic [ROW_W-1:0] vic_row_in,
  input  logic [COL_W-1:0] vic_col_in,
  output flt_kind_e        kind_q,
  output logic [ROW_W-1:0] agg_row_q,
  output logic [COL_W-1:0] agg_col_q,
  output logic [ROW_W-1:0] vic_row_q,
  output logic [COL_W-1:0] vic_col_q
);
  flt_kind_e kind_in;

  // Code 7 is mapped to a fault-free array.
  always_comb begin
    if (type_in == 3'd7) kind_in = FLT_NONE;
    else                 kind_in = flt_kind_e'(type_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= FLT_NONE;
      agg_row_q <= '0;
      agg_col_q <= '0;
      vic_row_q <= '0;
      vic_col_q <= '0;
    end else if (!busy) begin
      kind_q    <= kind_in;
      agg_row_q <= agg_row_in;
      agg_col_q <= agg_col_in;
      vic_row_q <= vic_row_in;
      vic_col_q <= vic_col_in;
    end
  end
endmodule

// File: rtl/flash_cell_plane.sv
module flash_cell_plane
  import flash_fault_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  flash_op_e            op,
  input  logic [ROW_W-1:0]     row,
  input  logic [COL_W-1:0]     col,
  input  flt_kind_e            kind,
  input  logic [ROW_W-1:0]     agg_row,
  input  logic [COL_W-1:0]     agg_col,
  input  logic [ROW_W-1:0]     vic_row,
  input  logic [COL_W-1:0]     vic_col,
  output logic                 rd_valid,
  output logic                 rd_data,
  output logic [ROWS*COLS-1:0] cells
);
  logic [ROWS-1:0][COLS-1:0] mem_q;
  logic [ROWS-1:0][COLS-1:0] mem_nxt;

  logic erase_go, prog_go, read_go;
  logic cell_cur, at_vic, at_agg, agg_off_vic;
  logic prog_block, trig, wl_kind, bl_kind;
  logic pull_low, push_high, rd_flip, leak;

  assign erase_go = accept && (op == OP_ERASE);
  assign prog_go  = accept && (op == OP_PROG);
  assign read_go  = accept && (op == OP_READ);

  assign cell_cur    = mem_q[row][col];
  assign at_vic      = (row == vic_row) && (col == vic_col);
  assign at_agg      = (row == agg_row) && (col == agg_col);
  assign agg_off_vic = (agg_row != vic_row) || (agg_col != vic_col);

  assign prog_block = (kind == FLT_OVER_ERASE) && at_vic;

  // Only a real 1->0 transition of the aggressor (off the victim) disturbs.
  assign trig    = prog_go && at_agg && agg_off_vic && cell_cur;
  assign wl_kind = (kind == FLT_WL_PROG) || (kind == FLT_WL_ERASE);
  assign bl_kind = (kind == FLT_BL_PROG) || (kind == FLT_BL_ERASE);

  always_comb begin
    pull_low  = 1'b0;
    push_high = 1'b0;
    if (trig && wl_kind && (agg_row == vic_row)) begin
      pull_low  = (kind == FLT_WL_PROG);
      push_high = (kind == FLT_WL_ERASE);
    end
    if (trig && bl_kind && (agg_col == vic_col)) begin
      pull_low  = (kind == FLT_BL_PROG);
      push_high = (kind == FLT_BL_ERASE);
    end
  end

  assign rd_flip = read_go && (kind == FLT_READ_DIST) && at_vic && !cell_cur;
  assign leak    = (kind == FLT_OVER_ERASE) && (col == vic_col) && (row != vic_row);

  // Per-cell next-state selection.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic hit, vic;
      assign hit = (row == ROW_W'(r)) && (col == COL_W'(c));
      assign vic = (vic_row == ROW_W'(r)) && (vic_col == COL_W'(c));
      assign mem_nxt[r][c] =
          erase_go                        ? 1'b1 :
          (prog_go && hit && !prog_block) ? 1'b0 :
          (vic && pull_low)               ? 1'b0 :
          (vic && (push_high || rd_flip)) ? 1'b1 :
                                            mem_q[r][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q    <= '1;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      mem_q    <= mem_nxt;
      rd_valid <= read_go;
      if (read_go) rd_data <= cell_cur | leak;
    end
  end

  assign cells = mem_q;
endmodule

// File: rtl/flash_disturb_array.sv
module flash_disturb_array
  import flash_fault_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int COLS      = 16,
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 3,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       flt_type,
  input  logic [ROW_W-1:0] flt_agg_row,
  input  logic [COL_W-1:0] flt_agg_col,
  input  logic [ROW_W-1:0] flt_vic_row,
  input  logic [COL_W-1:0] flt_vic_col,
  output logic             rd_valid,
  output logic             rd_data
);
  flash_op_e              op_e;
  logic                   busy, accept;
  flt_kind_e              cfg_kind_q;
  logic [ROW_W-1:0]       cfg_agg_row_q, cfg_vic_row_q;
  logic [COL_W-1:0]       cfg_agg_col_q, cfg_vic_col_q;
  logic [ROWS*COLS-1:0]   cell_state;

  assign op_e      = flash_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  flash_busy_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op_e), .busy(busy)
  );

  flash_fault_cfg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .type_in(flt_type),
    .agg_row_in(flt_agg_row), .agg_col_in(flt_agg_col),
    .vic_row_in(flt_vic_row), .vic_col_in(flt_vic_col),
    .kind_q(cfg_kind_q),
    .agg_row_q(cfg_agg_row_q), .agg_col_q(cfg_agg_col_q),
    .vic_row_q(cfg_vic_row_q), .vic_col_q(cfg_vic_col_q)
  );

  flash_cell_plane #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_plane (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op_e),
    .row(cmd_row), .col(cmd_col),
    .kind(cfg_kind_q),
    .agg_row(cfg_agg_row_q), .agg_col(cfg_agg_col_q),
    .vic_row(cfg_vic_row_q), .vic_col(cfg_vic_col_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .cells(cell_state)
  );
endmodule

// File: rtl/flash_disturb_array_chk.sv
module flash_disturb_array_chk #(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [1:0]           cmd_op,
  input logic [ROW_W-1:0]     cmd_row,
  input logic [COL_W-1:0]     cmd_col,
  input logic                 rd_valid,
  input logic [ROWS*COLS-1:0] cell_state,
  input logic [2:0]           cfg_kind_q,
  input logic [ROW_W-1:0]     cfg_vic_row_q,
  input logic [COL_W-1:0]     cfg_vic_col_q
);
  int  idx;
  logic acc, oe_vic;
  assign idx    = int'(cmd_row) * COLS + int'(cmd_col);
  assign acc    = cmd_valid && cmd_ready;
  assign oe_vic = (cfg_kind_q == 3'd6) && (cmd_row == cfg_vic_row_q) && (cmd_col == cfg_vic_col_q);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op != 2'd0) |=> !cmd_ready);

  // R2
  idle_cells_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(cell_state));

  // R3
  erase_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1) |=> (&cell_state));

  // R4
  prog_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2 && !oe_vic) |=> (cell_state[$past(idx)] == 1'b0));

  // R5
  rd_valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc && cmd_op == 2'd3));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> ($stable(cfg_kind_q) && $stable(cfg_vic_row_q) && $stable(cfg_vic_col_q)));
endmodule

bind flash_disturb_array flash_disturb_array_chk #(
  .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_valid(rd_valid),
  .cell_state(cell_state), .cfg_kind_q(cfg_kind_q),
  .cfg_vic_row_q(cfg_vic_row_q), .cfg_vic_col_q(cfg_vic_col_q)
);

// File: tb/flash_disturb_array_bench.sv
module flash_disturb_array_bench;
  localparam int ERASE_CYC = 8;
  localparam int PROG_CYC  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_row = '0, cmd_col = '0;
  logic [2:0] flt_type = '0;
  logic [3:0] flt_agg_row = '0, flt_agg_col = '0, flt_vic_row = '0, flt_vic_col = '0;
  logic rd_valid, rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_disturb_array #(.ROWS(16), .COLS(16), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_flash_disturb_array (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .flt_type(flt_type), .flt_agg_row(flt_agg_row), .flt_agg_col(flt_agg_col),
    .flt_vic_row(flt_vic_row), .flt_vic_col(flt_vic_col),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {op[11:10], row[9:6], col[5:2], check[1], expected[0]} on a fault-free array
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {2'd1, 4'd0,  4'd0,  1'b0, 1'b0},
    {2'd3, 4'd0,  4'd0,  1'b1, 1'b1},
    {2'd2, 4'd0,  4'd0,  1'b0, 1'b0},
    {2'd3, 4'd0,  4'd0,  1'b1, 1'b0},
    {2'd3, 4'd0,  4'd1,  1'b1, 1'b1},
    {2'd2, 4'd15, 4'd15, 1'b0, 1'b0},
    {2'd3, 4'd15, 4'd15, 1'b1, 1'b0},
    {2'd3, 4'd15, 4'd14, 1'b1, 1'b1},
    {2'd3, 4'd14, 4'd15, 1'b1, 1'b1},
    {2'd2, 4'd0,  4'd0,  1'b0, 1'b0},
    {2'd3, 4'd0,  4'd0,  1'b1, 1'b0},
    {2'd1, 4'd0,  4'd0,  1'b0, 1'b0},
    {2'd3, 4'd0,  4'd0,  1'b1, 1'b1},
    {2'd3, 4'd15, 4'd15, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] r, input logic [3:0] c);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = r; cmd_col = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] r, input logic [3:0] c, input logic exp);
    cmd(2'd3, r, c);
    check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    check({tag, " rd_data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic set_flt(input logic [2:0] t, input logic [3:0] ar, ac, vr, vc);
    while (!cmd_ready) @(negedge clk);
    flt_type = t; flt_agg_row = ar; flt_agg_col = ac; flt_vic_row = vr; flt_vic_col = vc;
    @(negedge clk);
  endtask

  task automatic busy_len(input string tag, input logic [1:0] op, input int exp);
    int n = 0;
    cmd(op, 4'd9, 4'd9);
    while (!cmd_ready) begin n++; @(negedge clk); end
    check(tag, 32'(n), 32'(exp));
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    rd_chk("R1 erased after reset", 4'd5, 4'd5, 1'b1);

    // Vector table: R3 R4 R5 on a fault-free array
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][1]) rd_chk($sformatf("R5 R4 R3 vec%0d", i), VEC[i][9:6], VEC[i][5:2], VEC[i][0]);
      else           cmd(VEC[i][11:10], VEC[i][9:6], VEC[i][5:2]);
    end

    // R2 busy lengths
    busy_len("R2 erase busy", 2'd1, ERASE_CYC);
    busy_len("R2 program busy", 2'd2, PROG_CYC);
    busy_len("R2 read busy", 2'd3, 1);

    // R2 command while busy is ignored
    cmd(2'd1, 4'd0, 4'd0);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_row = 4'd0; cmd_col = 4'd0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    rd_chk("R2 ignored program", 4'd0, 4'd0, 1'b1);

    // R6 config changed only while busy is not captured
    cmd(2'd1, 4'd0, 4'd0);
    flt_type = 3'd1; flt_agg_row = 4'd2; flt_agg_col = 4'd3; flt_vic_row = 4'd2; flt_vic_col = 4'd7;
    repeat (2) @(negedge clk);
    flt_type = 3'd0;
    cmd(2'd2, 4'd2, 4'd3);
    rd_chk("R6 busy cfg ignored", 4'd2, 4'd7, 1'b1);

    // R10 aggressor already 0 does not disturb
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd2, 4'd3);
    set_flt(3'd1, 4'd2, 4'd3, 4'd2, 4'd7);
    cmd(2'd2, 4'd2, 4'd3);
    rd_chk("R10 agg already 0", 4'd2, 4'd7, 1'b1);

    // R7 word-line program disturb
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd2, 4'd3);
    rd_chk("R7 victim pulled low", 4'd2, 4'd7, 1'b0);
    rd_chk("R7 aggressor programmed", 4'd2, 4'd3, 1'b0);
    rd_chk("R10 bystander", 4'd2, 4'd8, 1'b1);

    // R10 aggressor off the row does nothing
    set_flt(3'd1, 4'd5, 4'd3, 4'd2, 4'd7);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd5, 4'd3);
    rd_chk("R10 off-row agg", 4'd2, 4'd7, 1'b1);

    // R8 word-line erase disturb
    set_flt(3'd2, 4'd4, 4'd9, 4'd4, 4'd1);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd4, 4'd1);
    rd_chk("R8 victim programmed", 4'd4, 4'd1, 1'b0);
    cmd(2'd2, 4'd4, 4'd9);
    rd_chk("R8 victim pushed high", 4'd4, 4'd1, 1'b1);

    // R9 bit-line program disturb
    set_flt(3'd3, 4'd10, 4'd5, 4'd6, 4'd5);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd10, 4'd5);
    rd_chk("R9 bl program victim", 4'd6, 4'd5, 1'b0);

    // R9 bit-line erase disturb
    set_flt(3'd4, 4'd9, 4'd12, 4'd1, 4'd12);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd1, 4'd12);
    cmd(2'd2, 4'd9, 4'd12);
    rd_chk("R9 bl erase victim", 4'd1, 4'd12, 1'b1);

    // R11 read disturb
    set_flt(3'd5, 4'd0, 4'd0, 4'd7, 4'd7);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd7, 4'd7);
    cmd(2'd2, 4'd7, 4'd8);
    rd_chk("R11 first read", 4'd7, 4'd7, 1'b0);
    rd_chk("R11 after read", 4'd7, 4'd7, 1'b1);
    rd_chk("R11 other cell", 4'd7, 4'd8, 1'b0);
    rd_chk("R11 other cell again", 4'd7, 4'd8, 1'b0);

    // R12 over-erase
    set_flt(3'd6, 4'd0, 4'd0, 4'd3, 4'd11);
    cmd(2'd1, 4'd0, 4'd0);
    cmd(2'd2, 4'd3, 4'd11);
    rd_chk("R12 victim unprogrammable", 4'd3, 4'd11, 1'b1);
    cmd(2'd2, 4'd8, 4'd11);
    rd_chk("R12 column leak", 4'd8, 4'd11, 1'b1);
    cmd(2'd2, 4'd8, 4'd10);
    rd_chk("R12 other column", 4'd8, 4'd10, 1'b0);
    set_flt(3'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    rd_chk("R12 stored zero visible when fault off", 4'd8, 4'd11, 1'b0);

    finish_run();
  end
endmodule